// File: doc/BRIEF.md
# Debounced Dual-Edge Beat Period Meter

This block times a one-bit beat signal in units of the system clock. It runs two interval timers, one for rising transitions and one for falling transitions. Each timer reports the number of clocks since the previous accepted transition of the same polarity. The two timers share one output stream. A square beat of any duty cycle therefore yields two period samples per beat cycle: one taken at the rise and one taken at the fall.

The beat input is asynchronous, so it first passes through a two-flop synchronizer. After any transition is accepted, a programmable blanking window opens. Transitions that arrive inside that window are discarded, and each discarded transition raises a one-cycle bounce pulse. Intervals that run past the counter's range saturate, and the sample that ends such an interval is marked as an overflow. Filtering of the period stream belongs to the consumer.

Top module: `beat_period_meter`

## Requirements
- R1: While `rst` is high at a clock edge and after that edge, `sample_valid`, `bounce_flag`, `overflow_flag`, `sample_is_fall` and `period_out` are all 0.
- R2: A sample's `period_out` equals the number of clock edges between two consecutive accepted transitions of the same polarity. The sample is presented after the third rising clock edge that samples the new `beat_in` level (two synchronizer flops plus one output register).
- R3: Rising-based and falling-based intervals are timed independently. `sample_is_fall` is 0 for a rise-to-rise sample and 1 for a fall-to-fall sample, so a clean beat gives two samples per cycle.
- R4: `sample_valid` is high for exactly one cycle per accepted, timed transition.
- R5: After reset, the first accepted transition of each polarity starts its timer and produces no sample.
- R6: After any accepted transition, transitions of either polarity that occur within the next `debounce_len` clocks are ignored. A value of 0 disables blanking.
- R7: Each ignored transition produces a one-cycle `bounce_flag` pulse, aligned with the cycle in which an accepted transition would have produced its sample. A cycle with a bounce pulse never carries a sample.
- R8: A timer saturates at 2^CNT_W-1. The sample that ends a saturated interval reports 2^CNT_W-1 with `overflow_flag` high for that one cycle.
- R9: `period_out` and `sample_is_fall` hold their values between samples, and `overflow_flag` is 0 whenever `sample_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_in | input | 1 | Asynchronous beat signal to be timed |
| debounce_len | input | DB_W | Blanking window length in clocks after an accepted transition |
| period_out | output | CNT_W | Measured interval in clocks |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| sample_is_fall | output | 1 | 0 = rise-to-rise sample, 1 = fall-to-fall sample |
| bounce_flag | output | 1 | One-cycle pulse for a transition discarded by blanking |
| overflow_flag | output | 1 | Sample ended a saturated interval |

## Verification
The first stimulus is a symmetric square beat, which confirms the start-up rule and the basic interval count. An asymmetric duty cycle follows; its rise and fall samples differ in timing but not in value, which shows that the two timers run independently. A sweep of beat periods checks that the count tracks the input. Narrow glitches with the blanking window on and then off separate rejected transitions, which pulse the bounce flag, from accepted ones, which emit back-to-back samples. Long low and high stretches past the counter range exercise saturation and the overflow marking. A reset in the middle of the run confirms that the first-edge rule applies again.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_t;

  localparam int NUM_KINDS = 2;
endpackage

// File: rtl/bpm_edge_sync.sv
module bpm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise =  pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] &  pipe[STAGES];
endmodule

// File: rtl/bpm_blanker.sv
module bpm_blanker #(
  parameter int DB_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise_in,
  input  logic            fall_in,
  input  logic [DB_W-1:0] blank_len,
  output logic            acc_rise,
  output logic            acc_fall,
  output logic            reject
);
  logic [DB_W-1:0] remain;
  logic            open_win;
  logic            any_edge;

  assign open_win = (remain == '0);
  assign any_edge = rise_in | fall_in;
  assign acc_rise = rise_in & open_win;
  assign acc_fall = fall_in & open_win;
  assign reject   = any_edge & ~open_win;

  always_ff @(posedge clk) begin
    if (rst)                        remain <= '0;
    else if (any_edge && open_win)  remain <= blank_len;
    else if (!open_win)             remain <= remain - 1'b1;
  end

  // R6
  blank_load_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_rise || acc_fall) |=> (remain == $past(blank_len)));

  // R6
  blank_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (remain != '0) |=> (remain == $past(remain) - 1'b1) || acc_rise || acc_fall || (remain == '0));
endmodule

// File: rtl/bpm_span_counter.sv
module bpm_span_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  output logic             fire,
  output logic [CNT_W-1:0] span,
  output logic             sat
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (hit) begin
      cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
      armed <= 1'b1;
    end else if (cnt != MAXV) begin
      cnt   <= cnt + 1'b1;
    end
  end

  assign fire = hit & armed;
  assign span = cnt;
  assign sat  = (cnt == MAXV);

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (span == 1));

  // R5
  first_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !armed) |=> armed);
endmodule

// File: rtl/beat_period_meter.sv
module beat_period_meter
  import bpm_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int DB_W        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_in,
  input  logic [DB_W-1:0]  debounce_len,
  output logic [CNT_W-1:0] period_out,
  output logic             sample_valid,
  output logic             sample_is_fall,
  output logic             bounce_flag,
  output logic             overflow_flag
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic             raw_rise, raw_fall;
  logic             ok_rise, ok_fall, rejected;
  logic [NUM_KINDS-1:0] hits, fires, sats;
  logic [CNT_W-1:0] spans [NUM_KINDS];
  edge_kind_t       kind_q;

  bpm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (beat_in), .rise (raw_rise), .fall (raw_fall)
  );

  bpm_blanker #(.DB_W(DB_W)) u_blank (
    .clk (clk), .rst (rst), .rise_in (raw_rise), .fall_in (raw_fall),
    .blank_len (debounce_len), .acc_rise (ok_rise), .acc_fall (ok_fall),
    .reject (rejected)
  );

  assign hits[EDGE_RISE] = ok_rise;
  assign hits[EDGE_FALL] = ok_fall;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_timer
    bpm_span_counter #(.CNT_W(CNT_W)) u_span (
      .clk (clk), .rst (rst), .hit (hits[k]),
      .fire (fires[k]), .span (spans[k]), .sat (sats[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_out    <= '0;
      sample_valid  <= 1'b0;
      kind_q        <= EDGE_RISE;
      bounce_flag   <= 1'b0;
      overflow_flag <= 1'b0;
    end else begin
      sample_valid  <= |fires;
      bounce_flag   <= rejected;
      overflow_flag <= 1'b0;
      if (fires[EDGE_FALL]) begin
        period_out    <= spans[EDGE_FALL];
        kind_q        <= EDGE_FALL;
        overflow_flag <= sats[EDGE_FALL];
      end else if (fires[EDGE_RISE]) begin
        period_out    <= spans[EDGE_RISE];
        kind_q        <= EDGE_RISE;
        overflow_flag <= sats[EDGE_RISE];
      end
    end
  end

  assign sample_is_fall = (kind_q == EDGE_FALL);

  // R8
  ovf_max_chk: assert property (@(posedge clk) disable iff (rst)
    overflow_flag |-> (sample_valid && period_out == MAXV));

  // R7
  bounce_excl_chk: assert property (@(posedge clk) disable iff (rst)
    bounce_flag |-> !sample_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |-> ($stable(period_out) && $stable(sample_is_fall)));
endmodule

// File: tb/test_beat_period_meter.sv
module test_beat_period_meter;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int DBW  = 6;
  localparam int MAXP = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          beat = 1'b0;
  logic [DBW-1:0] dlen = '0;
  logic [CW-1:0] period_out;
  logic          sample_valid, sample_is_fall, bounce_flag, overflow_flag;

  beat_period_meter #(.CNT_W(CW), .DB_W(DBW), .SYNC_STAGES(2)) i_beat_period_meter (
    .clk (clk), .rst (rst), .beat_in (beat), .debounce_len (dlen),
    .period_out (period_out), .sample_valid (sample_valid),
    .sample_is_fall (sample_is_fall), .bounce_flag (bounce_flag),
    .overflow_flag (overflow_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  bit    done    = 0;
  string phase   = "R1 reset";

  // reference model state
  int q_in[$];
  int now_t, deadline;
  int last_t [2];
  bit armed  [2];
  int e_period; bit e_valid, e_fall, e_bounce, e_ovf;

  task automatic model_reset();
    q_in = '{0, 0, 0};
    now_t = 0; deadline = -1000000;
    for (int k = 0; k < 2; k++) begin last_t[k] = 0; armed[k] = 0; end
    e_period = 0; e_valid = 0; e_fall = 0; e_bounce = 0; e_ovf = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) model_reset();
    else begin
      int cur, prv, pol, d;
      bit edge_seen;
      now_t++;
      cur = q_in[1]; prv = q_in[2];
      edge_seen = (cur != prv);
      pol = (cur == 0) ? 1 : 0;
      e_valid = 0; e_bounce = 0; e_ovf = 0;
      if (edge_seen) begin
        if (now_t > deadline) begin
          deadline = now_t + int'(dlen);
          if (armed[pol]) begin
            d = now_t - last_t[pol];
            e_valid  = 1;
            e_fall   = (pol == 1);
            e_period = (d >= MAXP) ? MAXP : d;
            e_ovf    = (d >= MAXP);
          end
          armed[pol]  = 1;
          last_t[pol] = now_t;
        end else e_bounce = 1;
      end
      q_in.push_front(int'(beat));
      void'(q_in.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit bad = 0;
      vectors++;
      if (int'(period_out) != e_period) begin bad = 1;
        $display("FAIL R2 [%s] period_out=%0d expected %0d at t=%0d", phase, period_out, e_period, now_t); end
      if (sample_valid != e_valid) begin bad = 1;
        $display("FAIL R4 [%s] sample_valid=%0b expected %0b at t=%0d", phase, sample_valid, e_valid, now_t); end
      if (sample_is_fall != e_fall) begin bad = 1;
        $display("FAIL R3 [%s] sample_is_fall=%0b expected %0b at t=%0d", phase, sample_is_fall, e_fall, now_t); end
      if (bounce_flag != e_bounce) begin bad = 1;
        $display("FAIL R7 [%s] bounce_flag=%0b expected %0b at t=%0d", phase, bounce_flag, e_bounce, now_t); end
      if (overflow_flag != e_ovf) begin bad = 1;
        $display("FAIL R8 [%s] overflow_flag=%0b expected %0b at t=%0d", phase, overflow_flag, e_ovf, now_t); end
      if (bad) errors++;
    end
  end

  task automatic hold(input logic lvl, input int n);
    beat = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic check_reset_state();
    vectors++;
    if (sample_valid || bounce_flag || overflow_flag || sample_is_fall || period_out != 0) begin
      errors++;
      $display("FAIL R1 outputs v=%0b b=%0b o=%0b f=%0b p=%0d expected all 0",
               sample_valid, bounce_flag, overflow_flag, sample_is_fall, period_out);
    end
  endtask

  initial begin
    model_reset();
    dlen = 6'd3;
    rst  = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();                  // R1
    rst = 1'b0;

    phase = "R5 first edges, R2 square 20";
    hold(0, 5);
    for (int i = 0; i < 6; i++) begin hold(1, 10); hold(0, 10); end

    phase = "R3 asymmetric duty";
    for (int i = 0; i < 5; i++) begin hold(1, 6); hold(0, 17); end

    phase = "R2 period sweep";
    for (int p = 8; p <= 48; p += 8)
      for (int r = 0; r < 2; r++) begin hold(1, p/2); hold(0, p - p/2); end

    phase = "R6 R7 glitches with blanking";
    dlen = 6'd5;
    for (int i = 0; i < 3; i++) begin
      hold(1, 12); hold(0, 1); hold(1, 12); hold(0, 2); hold(1, 1); hold(0, 14);
    end

    phase = "R6 blanking disabled";
    dlen = 6'd0;
    for (int i = 0; i < 3; i++) begin hold(1, 1); hold(0, 1); hold(1, 1); hold(0, 9); end

    phase = "R8 saturation";
    dlen = 6'd2;
    hold(0, 300); hold(1, 10); hold(0, 10); hold(1, 260); hold(0, 5); hold(1, 10);
    hold(0, 254); hold(1, 3); hold(0, 20);

    phase = "R9 hold, R1 mid-run reset";
    hold(0, 30);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();                  // R1
    rst = 1'b0;

    phase = "R5 restart after reset";
    dlen = 6'd4;
    for (int i = 0; i < 4; i++) begin hold(1, 9); hold(0, 15); end
    hold(0, 10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 50000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule